// File: doc/BRIEF.md
# Panel Detect and Power-Up Sequencer

This block brings up an attached display panel through a register access engine. On an initialise command it first reads the panel's identification register at index 0x00. It classifies the panel from the returned value and then runs that panel type's stored bring-up script. Separate panel-on and panel-off commands run per-type scripts, using the panel type latched by the most recent identification read.

A script is a short list of entries held in a computed ROM. An entry is a register write (8-bit index, 16-bit value), a timed pause measured in wait units, or an end marker. The sequencer issues one access request at a time and holds it until the engine answers with done. A pause holds the request line low for a number of clock cycles that scales with the `WAIT_UNIT_CYC` parameter, so simulation can use a short unit and silicon a long one. On the end marker the block pulses `done_o` and returns to idle.

Top module: `panel_bringup_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `acc_req_o` are 0 and `panel_type_o` is 0.
- R2: Command codes on `cmd_i` are 0 = initialise, 1 = panel on and 2 = panel off. An initialise start raises a read request (`acc_wr_o`=0, index 0x00) one cycle later. An on or off start raises its first write request two cycles later.
- R3: When the identification read completes, `panel_type_o` becomes 0 if the returned data is 0x0139 and 1 for any other value. It holds that value until the next identification read completes.
- R4: Only one request is outstanding. `acc_req_o`, `acc_wr_o`, `acc_idx_o` and `acc_data_o` stay steady until `acc_done_i`, and the request drops in the following cycle. Two writes with nothing between them are separated by exactly one cycle with the request low.
- R5: A pause of U units between two accesses, or before the end marker, keeps the request low for exactly U*`WAIT_UNIT_CYC`+2 cycles.
- R6: The end marker produces a one-cycle `done_o` pulse one cycle after the last access completes, or after the last pause ends. During that pulse `busy_o` is 0 and `panel_type_o` holds the latched type.
- R7: `start_i` is ignored while `busy_o` is 1, whatever `cmd_i` holds, and the running script continues unchanged.
- R8: Type-0 initialise script: W07=0000, W13=0000, pause 1, W11=3304, W14=1300, W10=1A20, W13=0040, pause 5, W13=0060, W13=0070, pause 20, W07=0015, pause 5, W07=0017, W20=0000, W21=0000, W22=0000, end.
- R9: Type-1 initialise script: W07=0000, W12=0000, pause 1, W11=000C, W12=0A1C, W13=0022, W10=7404, pause 5, W12=065C, pause 20, W07=0009, pause 4, W07=0109, pause 4, W07=010B, end.
- R10: Type-0 on script: W00=0001, pause 1, W10=0000, pause 1, W11=3304, W10=1A20, W07=0015, pause 3, W20=0000, W21=0000, W22=0000, end. Type-0 off script: W07=0016, pause 4, W07=0004, pause 4, W10=1E21, pause 1, end.
- R11: Type-1 on script: W10=0400, pause 4, W07=0009, pause 4, W07=0109, pause 4, W07=010B, end. Type-1 off script: W0B=0109, W07=0009, pause 4, W07=0008, pause 4, W10=0400, W10=0401, pause 1, end.
- R12: A start with command code 3 is ignored: `busy_o` and `acc_req_o` stay 0.
- R13: A start raised in the same cycle as the `done_o` pulse is accepted as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start the command on `cmd_i` (sampled while idle) |
| cmd_i | input | 2 | Command code: 0 initialise, 1 on, 2 off, 3 none |
| busy_o | output | 1 | A command is running |
| done_o | output | 1 | One-cycle pulse when a script reaches its end |
| panel_type_o | output | 1 | Latched panel type: 0 for ID 0x0139, 1 otherwise |
| acc_req_o | output | 1 | Access request to the register engine |
| acc_wr_o | output | 1 | 1 = write, 0 = read |
| acc_idx_o | output | 8 | Register index |
| acc_data_o | output | 16 | Write data |
| acc_done_i | input | 1 | Engine completed the current request |
| acc_rdata_i | input | 16 | Read data, valid with `acc_done_i` |

## Verification
Two events can fall in the same cycle: the end-of-script `done_o` pulse and a fresh `start_i`. The bench raises `start_i` in exactly the cycle `done_o` is seen and expects the new command's first request at the normal start latency. It also pulses `start_i` with random command codes while accesses are pending, and expects each script's write order and pause gaps to come out unchanged. Engine latency and identification values are randomised, including 0x0138 next to the matching 0x0139.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    localparam int IDX_W = 8;
    localparam int DAT_W = 16;
    localparam int PC_W  = 5;

    localparam logic [DAT_W-1:0] PANEL0_ID = 16'h0139;

    localparam logic [1:0] CMD_INIT = 2'd0;
    localparam logic [1:0] CMD_ON   = 2'd1;
    localparam logic [1:0] CMD_OFF  = 2'd2;
    localparam logic [1:0] CMD_NONE = 2'd3;

    typedef enum logic [1:0] {
        OP_WR   = 2'd0,
        OP_WAIT = 2'd1,
        OP_END  = 2'd2
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IDX_W-1:0] idx;
        logic [DAT_W-1:0] arg;
    } ent_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ID,
        ST_EXEC,
        ST_ACC,
        ST_DLY
    } st_e;

    function automatic ent_t wr(input logic [IDX_W-1:0] i, input logic [DAT_W-1:0] d);
        ent_t e;
        e.op  = OP_WR;
        e.idx = i;
        e.arg = d;
        return e;
    endfunction

    function automatic ent_t pause(input logic [DAT_W-1:0] u);
        ent_t e;
        e.op  = OP_WAIT;
        e.idx = '0;
        e.arg = u;
        return e;
    endfunction

    function automatic ent_t fin();
        ent_t e;
        e.op  = OP_END;
        e.idx = '0;
        e.arg = '0;
        return e;
    endfunction

    // Bring-up of the panel answering with PANEL0_ID
    function automatic ent_t scr_init0(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h07, 16'h0000);
            5'd1:  return wr(8'h13, 16'h0000);
            5'd2:  return pause(16'd1);
            5'd3:  return wr(8'h11, 16'h3304);
            5'd4:  return wr(8'h14, 16'h1300);
            5'd5:  return wr(8'h10, 16'h1A20);
            5'd6:  return wr(8'h13, 16'h0040);
            5'd7:  return pause(16'd5);
            5'd8:  return wr(8'h13, 16'h0060);
            5'd9:  return wr(8'h13, 16'h0070);
            5'd10: return pause(16'd20);
            5'd11: return wr(8'h07, 16'h0015);
            5'd12: return pause(16'd5);
            5'd13: return wr(8'h07, 16'h0017);
            5'd14: return wr(8'h20, 16'h0000);
            5'd15: return wr(8'h21, 16'h0000);
            5'd16: return wr(8'h22, 16'h0000);
            default: return fin();
        endcase
    endfunction

    function automatic ent_t scr_init1(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h07, 16'h0000);
            5'd1:  return wr(8'h12, 16'h0000);
            5'd2:  return pause(16'd1);
            5'd3:  return wr(8'h11, 16'h000C);
            5'd4:  return wr(8'h12, 16'h0A1C);
            5'd5:  return wr(8'h13, 16'h0022);
            5'd6:  return wr(8'h10, 16'h7404);
            5'd7:  return pause(16'd5);
            5'd8:  return wr(8'h12, 16'h065C);
            5'd9:  return pause(16'd20);
            5'd10: return wr(8'h07, 16'h0009);
            5'd11: return pause(16'd4);
            5'd12: return wr(8'h07, 16'h0109);
            5'd13: return pause(16'd4);
            5'd14: return wr(8'h07, 16'h010B);
            default: return fin();
        endcase
    endfunction

    function automatic ent_t scr_on0(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h00, 16'h0001);
            5'd1:  return pause(16'd1);
            5'd2:  return wr(8'h10, 16'h0000);
            5'd3:  return pause(16'd1);
            5'd4:  return wr(8'h11, 16'h3304);
            5'd5:  return wr(8'h10, 16'h1A20);
            5'd6:  return wr(8'h07, 16'h0015);
            5'd7:  return pause(16'd3);
            5'd8:  return wr(8'h20, 16'h0000);
            5'd9:  return wr(8'h21, 16'h0000);
            5'd10: return wr(8'h22, 16'h0000);
            default: return fin();
        endcase
    endfunction

    function automatic ent_t scr_off0(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h07, 16'h0016);
            5'd1:  return pause(16'd4);
            5'd2:  return wr(8'h07, 16'h0004);
            5'd3:  return pause(16'd4);
            5'd4:  return wr(8'h10, 16'h1E21);
            5'd5:  return pause(16'd1);
            default: return fin();
        endcase
    endfunction

    function automatic ent_t scr_on1(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h10, 16'h0400);
            5'd1:  return pause(16'd4);
            5'd2:  return wr(8'h07, 16'h0009);
            5'd3:  return pause(16'd4);
            5'd4:  return wr(8'h07, 16'h0109);
            5'd5:  return pause(16'd4);
            5'd6:  return wr(8'h07, 16'h010B);
            default: return fin();
        endcase
    endfunction

    function automatic ent_t scr_off1(input logic [PC_W-1:0] pc);
        case (pc)
            5'd0:  return wr(8'h0B, 16'h0109);
            5'd1:  return wr(8'h07, 16'h0009);
            5'd2:  return pause(16'd4);
            5'd3:  return wr(8'h07, 16'h0008);
            5'd4:  return pause(16'd4);
            5'd5:  return wr(8'h10, 16'h0400);
            5'd6:  return wr(8'h10, 16'h0401);
            5'd7:  return pause(16'd1);
            default: return fin();
        endcase
    endfunction

endpackage

// File: rtl/pbs_script_rom.sv
module pbs_script_rom
    import pbs_pkg::*;
(
    input  logic [1:0]      cmd_i,
    input  logic            ptype_i,
    input  logic [PC_W-1:0] pc_i,
    output ent_t            ent_o
);

    always_comb begin
        case ({cmd_i, ptype_i})
            {CMD_INIT, 1'b0}: ent_o = scr_init0(pc_i);
            {CMD_INIT, 1'b1}: ent_o = scr_init1(pc_i);
            {CMD_ON,   1'b0}: ent_o = scr_on0(pc_i);
            {CMD_ON,   1'b1}: ent_o = scr_on1(pc_i);
            {CMD_OFF,  1'b0}: ent_o = scr_off0(pc_i);
            {CMD_OFF,  1'b1}: ent_o = scr_off1(pc_i);
            default:          ent_o = fin();
        endcase
    end

endmodule

// File: rtl/pbs_wait_timer.sv
module pbs_wait_timer
    import pbs_pkg::*;
#(
    parameter int UNIT_CYC  = 1000,
    parameter int MAX_UNITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [DAT_W-1:0] units_i,
    output logic             last_o
);

    localparam int CW = $clog2(MAX_UNITS * UNIT_CYC + 1);

    logic [CW-1:0] cnt_q;
    logic [31:0]   span;

    assign span   = 32'(units_i) * 32'(UNIT_CYC);
    assign last_o = (cnt_q <= CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= CW'(span);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

endmodule

// File: rtl/pbs_seq_fsm.sv
module pbs_seq_fsm
    import pbs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [1:0]       cmd_i,
    input  logic             acc_done_i,
    input  logic [DAT_W-1:0] acc_rdata_i,
    input  ent_t             ent_i,
    input  logic             tmr_last_i,
    output logic [1:0]       cmd_o,
    output logic [PC_W-1:0]  pc_o,
    output logic             tmr_load_o,
    output logic [DAT_W-1:0] tmr_units_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             panel_type_o,
    output logic             acc_req_o,
    output logic             acc_wr_o,
    output logic [IDX_W-1:0] acc_idx_o,
    output logic [DAT_W-1:0] acc_data_o
);

    st_e              st_q;
    logic [1:0]       cmd_q;
    logic [PC_W-1:0]  pc_q;
    logic             type_q;
    logic             done_q;
    logic             req_q;
    logic             wr_q;
    logic [IDX_W-1:0] idx_q;
    logic [DAT_W-1:0] dat_q;

    assign cmd_o        = cmd_q;
    assign pc_o         = pc_q;
    assign tmr_load_o   = (st_q == ST_EXEC) && (ent_i.op == OP_WAIT);
    assign tmr_units_o  = ent_i.arg;
    assign busy_o       = (st_q != ST_IDLE);
    assign done_o       = done_q;
    assign panel_type_o = type_q;
    assign acc_req_o    = req_q;
    assign acc_wr_o     = wr_q;
    assign acc_idx_o    = idx_q;
    assign acc_data_o   = dat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cmd_q  <= CMD_INIT;
            pc_q   <= '0;
            type_q <= 1'b0;
            done_q <= 1'b0;
            req_q  <= 1'b0;
            wr_q   <= 1'b0;
            idx_q  <= '0;
            dat_q  <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i && (cmd_i != CMD_NONE)) begin
                        cmd_q <= cmd_i;
                        pc_q  <= '0;
                        if (cmd_i == CMD_INIT) begin
                            st_q  <= ST_ID;
                            req_q <= 1'b1;
                            wr_q  <= 1'b0;
                            idx_q <= '0;
                            dat_q <= '0;
                        end else begin
                            st_q <= ST_EXEC;
                        end
                    end
                end
                ST_ID: begin
                    if (acc_done_i) begin
                        req_q  <= 1'b0;
                        type_q <= (acc_rdata_i != PANEL0_ID);
                        st_q   <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    case (ent_i.op)
                        OP_WR: begin
                            req_q <= 1'b1;
                            wr_q  <= 1'b1;
                            idx_q <= ent_i.idx;
                            dat_q <= ent_i.arg;
                            st_q  <= ST_ACC;
                        end
                        OP_WAIT: st_q <= ST_DLY;
                        default: begin
                            done_q <= 1'b1;
                            st_q   <= ST_IDLE;
                        end
                    endcase
                end
                ST_ACC: begin
                    if (acc_done_i) begin
                        req_q <= 1'b0;
                        pc_q  <= pc_q + PC_W'(1);
                        st_q  <= ST_EXEC;
                    end
                end
                ST_DLY: begin
                    if (tmr_last_i) begin
                        pc_q <= pc_q + PC_W'(1);
                        st_q <= ST_EXEC;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/panel_bringup_seq.sv
module panel_bringup_seq
    import pbs_pkg::*;
#(
    parameter int WAIT_UNIT_CYC = 1000,
    parameter int MAX_UNITS     = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic [1:0]  cmd_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        panel_type_o,
    output logic        acc_req_o,
    output logic        acc_wr_o,
    output logic [7:0]  acc_idx_o,
    output logic [15:0] acc_data_o,
    input  logic        acc_done_i,
    input  logic [15:0] acc_rdata_i
);

    logic [1:0]       cmd_sel;
    logic [PC_W-1:0]  pc;
    ent_t             ent;
    logic             tmr_load;
    logic [DAT_W-1:0] tmr_units;
    logic             tmr_last;

    pbs_script_rom u_rom (
        .cmd_i   (cmd_sel),
        .ptype_i (panel_type_o),
        .pc_i    (pc),
        .ent_o   (ent)
    );

    pbs_wait_timer #(
        .UNIT_CYC  (WAIT_UNIT_CYC),
        .MAX_UNITS (MAX_UNITS)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .units_i (tmr_units),
        .last_o  (tmr_last)
    );

    pbs_seq_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .cmd_i        (cmd_i),
        .acc_done_i   (acc_done_i),
        .acc_rdata_i  (acc_rdata_i),
        .ent_i        (ent),
        .tmr_last_i   (tmr_last),
        .cmd_o        (cmd_sel),
        .pc_o         (pc),
        .tmr_load_o   (tmr_load),
        .tmr_units_o  (tmr_units),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .panel_type_o (panel_type_o),
        .acc_req_o    (acc_req_o),
        .acc_wr_o     (acc_wr_o),
        .acc_idx_o    (acc_idx_o),
        .acc_data_o   (acc_data_o)
    );

endmodule

// File: rtl/pbs_seq_chk.sv
module pbs_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy_o,
    input logic        done_o,
    input logic        panel_type_o,
    input logic        acc_req_o,
    input logic        acc_wr_o,
    input logic [7:0]  acc_idx_o,
    input logic [15:0] acc_data_o,
    input logic        acc_done_i,
    input logic [15:0] acc_rdata_i
);

    p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_req_o && !acc_done_i) |=>
            (acc_req_o && $stable(acc_wr_o) && $stable(acc_idx_o) && $stable(acc_data_o)));

    p_req_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (acc_req_o && acc_done_i) |=> !acc_req_o);

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !acc_req_o);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    p_type_set_r3: assert property (@(posedge clk) disable iff (rst)
        (acc_req_o && !acc_wr_o && acc_done_i) |=>
            (panel_type_o == ($past(acc_rdata_i) != 16'h0139)));

    p_type_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !(acc_req_o && !acc_wr_o && acc_done_i) |=> $stable(panel_type_o));

endmodule

bind panel_bringup_seq pbs_seq_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .panel_type_o (panel_type_o),
    .acc_req_o    (acc_req_o),
    .acc_wr_o     (acc_wr_o),
    .acc_idx_o    (acc_idx_o),
    .acc_data_o   (acc_data_o),
    .acc_done_i   (acc_done_i),
    .acc_rdata_i  (acc_rdata_i)
);

// File: tb/panel_bringup_seq_tb_top.sv
`timescale 1ns/1ps
module panel_bringup_seq_tb_top;

    localparam int UNIT = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic        busy_o, done_o, panel_type_o;
    logic        acc_req_o, acc_wr_o;
    logic [7:0]  acc_idx_o;
    logic [15:0] acc_data_o;
    logic        acc_done_i = 1'b0;
    logic [15:0] acc_rdata_i = 16'h0;

    int n_cmp = 0;
    int n_bad = 0;
    int model_type = 0;
    bit fin_seen = 0;

    always #2.5 clk = ~clk;

    panel_bringup_seq #(.WAIT_UNIT_CYC(UNIT), .MAX_UNITS(32)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .cmd_i(cmd_i),
        .busy_o(busy_o), .done_o(done_o), .panel_type_o(panel_type_o),
        .acc_req_o(acc_req_o), .acc_wr_o(acc_wr_o), .acc_idx_o(acc_idx_o),
        .acc_data_o(acc_data_o), .acc_done_i(acc_done_i), .acc_rdata_i(acc_rdata_i)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // entry encoding: {op[1:0], idx[7:0], val[15:0]}; op 0 write, 1 pause, 2 end
    function automatic logic [25:0] W(input logic [7:0] i, input logic [15:0] v);
        return {2'd0, i, v};
    endfunction
    function automatic logic [25:0] P(input int u);
        return {2'd1, 8'h00, 16'(u)};
    endfunction
    localparam logic [25:0] E = {2'd2, 24'h0};

    // Expected scripts taken from R8 to R11
    function automatic logic [25:0] ref_ent(input int cmd, input int ty, input int k);
        if (cmd == 0 && ty == 0) begin
            case (k)
                0: return W(8'h07,16'h0000);  1: return W(8'h13,16'h0000);  2: return P(1);
                3: return W(8'h11,16'h3304);  4: return W(8'h14,16'h1300);  5: return W(8'h10,16'h1A20);
                6: return W(8'h13,16'h0040);  7: return P(5);               8: return W(8'h13,16'h0060);
                9: return W(8'h13,16'h0070);  10: return P(20);             11: return W(8'h07,16'h0015);
                12: return P(5);              13: return W(8'h07,16'h0017); 14: return W(8'h20,16'h0000);
                15: return W(8'h21,16'h0000); 16: return W(8'h22,16'h0000); default: return E;
            endcase
        end else if (cmd == 0) begin
            case (k)
                0: return W(8'h07,16'h0000);  1: return W(8'h12,16'h0000);  2: return P(1);
                3: return W(8'h11,16'h000C);  4: return W(8'h12,16'h0A1C);  5: return W(8'h13,16'h0022);
                6: return W(8'h10,16'h7404);  7: return P(5);               8: return W(8'h12,16'h065C);
                9: return P(20);              10: return W(8'h07,16'h0009); 11: return P(4);
                12: return W(8'h07,16'h0109); 13: return P(4);              14: return W(8'h07,16'h010B);
                default: return E;
            endcase
        end else if (cmd == 1 && ty == 0) begin
            case (k)
                0: return W(8'h00,16'h0001);  1: return P(1);               2: return W(8'h10,16'h0000);
                3: return P(1);               4: return W(8'h11,16'h3304);  5: return W(8'h10,16'h1A20);
                6: return W(8'h07,16'h0015);  7: return P(3);               8: return W(8'h20,16'h0000);
                9: return W(8'h21,16'h0000);  10: return W(8'h22,16'h0000); default: return E;
            endcase
        end else if (cmd == 2 && ty == 0) begin
            case (k)
                0: return W(8'h07,16'h0016);  1: return P(4);  2: return W(8'h07,16'h0004);
                3: return P(4);               4: return W(8'h10,16'h1E21);  5: return P(1);
                default: return E;
            endcase
        end else if (cmd == 1) begin
            case (k)
                0: return W(8'h10,16'h0400);  1: return P(4);  2: return W(8'h07,16'h0009);
                3: return P(4);               4: return W(8'h07,16'h0109);  5: return P(4);
                6: return W(8'h07,16'h010B);  default: return E;
            endcase
        end else begin
            case (k)
                0: return W(8'h0B,16'h0109);  1: return W(8'h07,16'h0009);  2: return P(4);
                3: return W(8'h07,16'h0008);  4: return P(4);  5: return W(8'h10,16'h0400);
                6: return W(8'h10,16'h0401);  7: return P(1);  default: return E;
            endcase
        end
    endfunction

    function automatic string script_tag(input int cmd, input int ty);
        if (cmd == 0) return (ty == 0) ? "R8" : "R9";
        return (ty == 0) ? "R10" : "R11";
    endfunction

    // Engine model: random latency, optional start noise while busy (R7)
    task automatic serve(input logic [15:0] rd, input bit noise);
        int lat;
        logic [7:0]  i0;
        logic [15:0] d0;
        logic        w0;
        lat = $urandom_range(0, 3);
        i0 = acc_idx_o; d0 = acc_data_o; w0 = acc_wr_o;
        for (int j = 0; j < lat; j++) begin
            if (noise) begin
                start_i = 1'($urandom_range(0, 1));
                cmd_i   = 2'($urandom_range(0, 3));
            end
            @(negedge clk);
            chk(acc_req_o && acc_idx_o == i0 && acc_data_o == d0 && acc_wr_o == w0,
                "R4 request held", {15'd0, acc_req_o, acc_data_o}, {15'd0, 1'b1, d0});
        end
        acc_done_i  = 1'b1;
        acc_rdata_i = rd;
        @(negedge clk);
        acc_done_i = 1'b0;
        start_i    = 1'b0;
        acc_rdata_i = 16'($urandom);
    endtask

    task automatic run_cmd(input int cmd, input logic [15:0] idv, input bit noise, input bit now);
        int g;
        int exp_gap;
        logic [25:0] e;
        string tg;
        if (!now) @(negedge clk);
        start_i = 1'b1;
        cmd_i   = 2'(cmd);
        @(negedge clk);
        start_i = 1'b0;
        fin_seen = 0;
        if (cmd == 3) begin
            for (int j = 0; j < 4; j++) begin
                chk(!busy_o && !acc_req_o, "R12 no-op command", {busy_o, acc_req_o}, 0);
                @(negedge clk);
            end
            return;
        end
        if (cmd == 0) begin
            chk(acc_req_o && !acc_wr_o && acc_idx_o == 8'h00, now ? "R13 restart read" : "R2 id read",
                {acc_req_o, acc_wr_o, acc_idx_o}, {1'b1, 1'b0, 8'h00});
            serve(idv, noise);
            model_type = (idv == 16'h0139) ? 0 : 1;
            chk(panel_type_o == 1'(model_type), "R3 panel type", panel_type_o, model_type);
        end
        tg = script_tag(cmd, model_type);
        exp_gap = 1;
        for (int k = 0; k < 32; k++) begin
            e = ref_ent(cmd, model_type, k);
            if (e[25:24] == 2'd1) begin
                exp_gap += int'(e[15:0]) * UNIT + 1;
                continue;
            end
            g = 0;
            while (!(e[25:24] == 2'd2 ? done_o : acc_req_o) && g < 400) begin
                g++;
                @(negedge clk);
            end
            chk(g == exp_gap, (k == 0 && cmd != 0) ? (now ? "R13 restart" : "R2 first write")
                : (exp_gap > 1 ? "R5 pause length" : "R4 write spacing"), g, exp_gap);
            if (e[25:24] == 2'd2) begin
                chk(done_o && !busy_o && panel_type_o == 1'(model_type), "R6 done pulse",
                    {done_o, busy_o, panel_type_o}, {1'b1, 1'b0, 1'(model_type)});
                fin_seen = 1;
                break;
            end
            chk(acc_wr_o && acc_idx_o == e[23:16] && acc_data_o == e[15:0], tg,
                {acc_wr_o, acc_idx_o, acc_data_o}, {1'b1, e[23:0]});
            serve(16'($urandom), noise);
            exp_gap = 1;
        end
    endtask

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        chk(!busy_o && !done_o && !acc_req_o && !panel_type_o, "R1 reset state",
            {busy_o, done_o, acc_req_o, panel_type_o}, 0);
        run_cmd(3, 0, 0, 0);                 // R12
        run_cmd(1, 0, 0, 0);                 // on with reset type 0
        run_cmd(0, 16'h0139, 0, 0);          // R8
        run_cmd(2, 0, 0, 1);                 // R13 back to back off
        run_cmd(0, 16'h0138, 1, 0);          // R9 near-miss ID, R7 noise
        run_cmd(2, 0, 1, 1);
        run_cmd(1, 0, 0, 0);
        run_cmd(0, 16'h8139, 0, 1);
        for (int it = 0; it < 14; it++) begin
            int c;
            logic [15:0] idv;
            bit b2b;
            c   = $urandom_range(0, 3);
            idv = ($urandom_range(0, 1) == 1) ? 16'h0139 : 16'($urandom);
            b2b = fin_seen && ($urandom_range(0, 1) == 1);
            run_cmd(c, idv, 1'($urandom_range(0, 1)), b2b);
        end
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule